// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned words and reports whether the first is greater than, less than or equal to the second. It is built from narrow comparator slices. Each slice works out the relation of its own pair of nibbles. It then combines that result with a relation passed in from the slice below it. A difference in the slice's own nibbles decides the result. When its nibbles match, the slice passes on whatever the lower slices decided.

The top level joins `NUM_SLICES` slices of `SLICE_W` bits into one word comparator. With the defaults, three 4-bit slices compare two 12-bit words. The lowest slice receives a fixed "equal so far" relation. Each slice output feeds the cascade input of the next slice up, and the top slice drives the three result pins. The path is purely combinational.

A parameter chooses how each slice finds its local relation. One variant uses a relational operator. The other scans bit pairs from the most significant end until the first pair that differs.

Top module: `magcmp_chain`

## Requirements
- R1: `a_gt_b` is 1 exactly when `a_word` is greater than `b_word`, with both read as unsigned numbers.
- R2: `a_lt_b` is 1 exactly when `a_word` is less than `b_word`, with both read as unsigned numbers.
- R3: `a_eq_b` is 1 exactly when `a_word` equals `b_word`.
- R4: Exactly one of `a_gt_b`, `a_lt_b` and `a_eq_b` is 1 for every input pair.
- R5: When the most significant nibble (bits 11..8 by default) differs between the words, the result follows that nibble alone, whatever the lower bits hold.
- R6: A slice whose two nibbles are equal passes its incoming cascade relation through unchanged. A difference in a lower nibble therefore reaches the outputs when every higher nibble matches.
- R7: A slice asserts greater when its own nibble of A is larger, or when its nibbles match and its cascade greater input is 1.
- R8: A slice asserts equal only when its nibbles match and its cascade equal input is 1.
- R9: A slice asserts less when its own nibble of A is smaller, or when its nibbles match and its cascade less input is 1.
- R10: The least significant slice receives equal=1, greater=0, less=0 as its cascade input. Two identical words therefore give `a_eq_b`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | SLICE_W*NUM_SLICES (12) | First operand, unsigned |
| b_word | input | SLICE_W*NUM_SLICES (12) | Second operand, unsigned |
| a_gt_b | output | 1 | First operand is greater |
| a_lt_b | output | 1 | First operand is less |
| a_eq_b | output | 1 | Operands are equal |

## Verification
The in-line assertions assume that every cascade relation entering a slice is one-hot. The chain meets this by construction: it starts from the fixed equal relation, and each slice produces a one-hot result from a one-hot input. The assertions also assume fully known operand bits. The bench therefore drives only 0/1 values and applies new operands well away from the sampling edge, so no check sees a half-settled relation. The stimulus mixes random pairs with every case where exactly one nibble differs. This covers both the local-decides path and the pass-through path of each slice.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
   // relation between two operands, one-hot when valid
   typedef struct packed {
      logic gt;
      logic lt;
      logic eq;
   } rel_t;

   // relation injected below the least significant slice
   localparam rel_t REL_TIE = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

   // variants for the local compare
   localparam int LOCAL_OPERATOR = 0;
   localparam int LOCAL_MSB_SCAN = 1;
endpackage

// File: rtl/magcmp_local.sv
module magcmp_local
   import magcmp_pkg::*;
#(
   parameter int W     = 4,
   parameter int STYLE = LOCAL_MSB_SCAN
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output rel_t         rel
);
   if (W < 1) begin : g_bad_width
      $error("magcmp_local: W must be at least 1");
   end
   if (STYLE != LOCAL_OPERATOR && STYLE != LOCAL_MSB_SCAN) begin : g_bad_style
      $error("magcmp_local: unknown STYLE");
   end

   if (STYLE == LOCAL_OPERATOR) begin : g_operator
      assign rel.gt = (a > b);
      assign rel.lt = (a < b);
      assign rel.eq = (a == b);
   end else begin : g_scan
      logic found;
      logic a_bit;
      always_comb begin
         found = 1'b0;
         a_bit = 1'b0;
         for (int i = W - 1; i >= 0; i--) begin
            if (!found && (a[i] != b[i])) begin
               found = 1'b1;
               a_bit = a[i];
            end
         end
      end
      assign rel.gt = found & a_bit;
      assign rel.lt = found & ~a_bit;
      assign rel.eq = ~found;
   end

   // local relation must be one-hot (R4)
   always_comb begin
      assert_local_onehot_R4: assert ($onehot({rel.gt, rel.lt, rel.eq}))
         else $error("local relation not one-hot");
   end
endmodule

// File: rtl/magcmp_merge.sv
module magcmp_merge
   import magcmp_pkg::*;
(
   input  rel_t loc,
   input  rel_t cin,
   output rel_t cout
);
   assign cout.gt = loc.gt | (loc.eq & cin.gt);
   assign cout.lt = loc.lt | (loc.eq & cin.lt);
   assign cout.eq = loc.eq & cin.eq;
endmodule

// File: rtl/magcmp_slice.sv
module magcmp_slice
   import magcmp_pkg::*;
#(
   parameter int W     = 4,
   parameter int STYLE = LOCAL_MSB_SCAN
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  rel_t         cin,
   output rel_t         cout
);
   rel_t loc_rel;

   magcmp_local #(.W(W), .STYLE(STYLE)) u_local (
      .a   (a),
      .b   (b),
      .rel (loc_rel)
   );

   magcmp_merge u_merge (
      .loc  (loc_rel),
      .cin  (cin),
      .cout (cout)
   );

   always_comb begin
      if (a == b) begin
         assert_pass_through_R6: assert (cout == cin)
            else $error("matching nibbles did not pass cascade through");
      end
      if (a > b) begin
         assert_greater_R7: assert (cout.gt && !cout.lt && !cout.eq)
            else $error("larger nibble did not give greater");
      end
      if (a < b) begin
         assert_less_R9: assert (cout.lt && !cout.gt && !cout.eq)
            else $error("smaller nibble did not give less");
      end
      if (!cin.eq) begin
         assert_equal_needs_cin_R8: assert (!cout.eq)
            else $error("equal asserted without cascade equal");
      end
   end
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
   import magcmp_pkg::*;
#(
   parameter int SLICE_W     = 4,
   parameter int NUM_SLICES  = 3,
   parameter int LOCAL_STYLE = LOCAL_MSB_SCAN,
   localparam int WORD_W     = SLICE_W * NUM_SLICES
) (
   input  logic [WORD_W-1:0] a_word,
   input  logic [WORD_W-1:0] b_word,
   output logic              a_gt_b,
   output logic              a_lt_b,
   output logic              a_eq_b
);
   if (NUM_SLICES < 1) begin : g_bad_count
      $error("magcmp_chain: NUM_SLICES must be at least 1");
   end

   rel_t link [NUM_SLICES+1];

   // least significant slice starts from "equal so far" (R10)
   assign link[0] = REL_TIE;

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      magcmp_slice #(.W(SLICE_W), .STYLE(LOCAL_STYLE)) u_slice (
         .a    (a_word[s*SLICE_W +: SLICE_W]),
         .b    (b_word[s*SLICE_W +: SLICE_W]),
         .cin  (link[s]),
         .cout (link[s+1])
      );
   end

   assign a_gt_b = link[NUM_SLICES].gt;
   assign a_lt_b = link[NUM_SLICES].lt;
   assign a_eq_b = link[NUM_SLICES].eq;

   always_comb begin
      assert_result_onehot_R4: assert ($onehot({a_gt_b, a_lt_b, a_eq_b}))
         else $error("final relation not one-hot");
      assert_equal_words_R3: assert (a_eq_b == (a_word == b_word))
         else $error("equal output disagrees with operands");
      if (a_word == b_word) begin
         assert_tie_seed_R10: assert (a_eq_b)
            else $error("identical words not reported equal");
      end
   end
endmodule

// File: tb/tb_magcmp_chain.sv
module tb_magcmp_chain;
   localparam int SW = 4;
   localparam int NS = 3;
   localparam int WW = SW * NS;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [WW-1:0] a_word = '0;
   logic [WW-1:0] b_word = '0;
   logic          a_gt_b, a_lt_b, a_eq_b;
   int            total = 0;
   int            bad = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   magcmp_chain #(.SLICE_W(SW), .NUM_SLICES(NS)) dut (
      .a_word (a_word),
      .b_word (b_word),
      .a_gt_b (a_gt_b),
      .a_lt_b (a_lt_b),
      .a_eq_b (a_eq_b)
   );

   // behavioural reference: integer relations, compared at each falling edge
   task automatic check_now(input string req);
      int ai, bi;
      logic eg, el, ee;
      ai = int'(a_word);
      bi = int'(b_word);
      eg = (ai > bi);
      el = (ai < bi);
      ee = (ai == bi);
      total++;
      if ({a_gt_b, a_lt_b, a_eq_b} !== {eg, el, ee}) begin
         bad++;
         $display("FAIL %s a=%0d b=%0d actual gt/lt/eq=%b%b%b expected=%b%b%b",
                  req, ai, bi, a_gt_b, a_lt_b, a_eq_b, eg, el, ee);
      end
      total++;
      if (($countones({a_gt_b, a_lt_b, a_eq_b}) != 1)) begin
         bad++;
         $display("FAIL R4 a=%0d b=%0d actual ones=%0d expected=1",
                  ai, bi, $countones({a_gt_b, a_lt_b, a_eq_b}));
      end
   endtask

   task automatic apply(input logic [WW-1:0] av, input logic [WW-1:0] bv,
                        input string req);
      @(posedge clk);
      #2;
      a_word = av;
      b_word = bv;
      @(negedge clk);
      check_now(req);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [WW-1:0] base;
      logic [WW-1:0] av, bv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_now("R10 reset-state equal");
      rst = 1'b0;

      // identical words, all nibble patterns at the ends
      apply('0, '0, "R10 R3 R8 zero words");
      apply('1, '1, "R3 R8 all ones");
      apply(12'hA5C, 12'hA5C, "R3 R8 mixed equal");

      // extremes
      apply('1, '0, "R1 max vs zero");
      apply('0, '1, "R2 zero vs max");
      apply(12'h800, 12'h7FF, "R1 R5 msb decides");
      apply(12'h7FF, 12'h800, "R2 R5 msb decides");

      // random vectors
      for (int n = 0; n < 400; n++) begin
         av = WW'($urandom);
         bv = (n % 5 == 0) ? av : WW'($urandom);
         if (av > bv)      apply(av, bv, "R1 random");
         else if (av < bv) apply(av, bv, "R2 random");
         else              apply(av, bv, "R3 random");
      end

      // exactly one nibble differs: every pair of nibble values
      for (int k = 0; k < NS; k++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               if (x != y) begin
                  base = WW'($urandom);
                  av = base;
                  bv = base;
                  av[k*SW +: SW] = SW'(x);
                  bv[k*SW +: SW] = SW'(y);
                  if (k == NS - 1)
                     apply(av, bv, "R5 top nibble differs");
                  else if (x > y)
                     apply(av, bv, "R6 R7 lower nibble greater passes up");
                  else
                     apply(av, bv, "R6 R9 lower nibble less passes up");
               end
            end
         end
      end

      // top nibble overrides opposite lower nibbles
      apply(12'h9_00, 12'h8_FF, "R5 R1 top overrides lower");
      apply(12'h8_FF, 12'h9_00, "R5 R2 top overrides lower");
      apply(12'h3_4F, 12'h3_50, "R6 R9 middle decides");
      apply(12'h3_51, 12'h3_50, "R6 R7 bottom decides");
      apply(12'h3_50, 12'h3_50, "R8 all equal");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule